// File: doc/BRIEF.md
# Write-Protected Configuration Register Writer

This block sits behind the byte layer of an I2C target and runs write transactions into a small set of stored configuration registers. The bus front end hands over one byte at a time with a one-cycle valid pulse. It also flags start and stop conditions. The block answers every byte with an acknowledge decision one cycle later. A transaction is a target-address byte, then a command byte that picks the register, then any number of data bytes. Each accepted data byte produces a one-cycle update strobe with the register index and the byte, and the selected register takes the byte on the next clock.

A write-protect input guards the stored registers. While it is high, the address and command bytes are still acknowledged. Each data byte that completes while protection is high is refused and leaves the registers untouched. Protection is sampled on each data byte, so it can change inside a transaction. After reset every stored register holds zero and the transaction logic waits for an address byte.

Top module: `i2cw_top`

## Requirements
- R1: After reset all stored registers read zero, ack_valid and upd_stb are low, and the first byte received is treated as an address byte.
- R2: An address byte is acknowledged only when bits [7:1] equal DEV_ADDR (default 7'h50) and bit 0 (read/write) is 0, i.e. byte 8'hA0. Any other address byte is refused, and every later byte up to the next start or stop is refused as well.
- R3: After an acknowledged address, the command byte is always acknowledged, whatever the write-protect level and whatever the command value.
- R4: A data byte that arrives while write-protect is 0 and after a valid command is acknowledged. In the same cycle as that acknowledge, upd_stb is high for exactly one cycle, with upd_idx equal to the register index and upd_data equal to the byte.
- R5: Register i (command code CMD_BASE+i, default 8'h10 for register 0 and 8'h11 for register 1) takes the low REG_W bits (default 6) of an accepted byte one cycle after the strobe. At all other times it holds its value. reg_q places register i at bits [i*REG_W +: REG_W].
- R6: A data byte that completes while write-protect is 1 is not acknowledged, raises no strobe and changes no register.
- R7: Write-protect is sampled separately on each data byte. Within one transaction the protected bytes are refused and the unprotected bytes are written.
- R8: An unknown command code is acknowledged, but its data bytes are refused and update nothing.
- R9: Consecutive data bytes in one transaction all go to the register chosen by the command byte, and the last accepted byte wins.
- R10: A start or a stop returns the block to waiting for an address byte, and a byte that arrives in the same cycle is ignored.
- R11: ack_valid is high exactly in the cycle after each byte_valid pulse that has no start or stop beside it, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp | input | 1 | Write protect, 1 blocks register writes |
| bus_start | input | 1 | Start or repeated start seen on the bus (one-cycle pulse) |
| bus_stop | input | 1 | Stop seen on the bus (one-cycle pulse) |
| byte_valid | input | 1 | A received byte is present on byte_data |
| byte_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision for the previous byte is valid |
| ack | output | 1 | 1 = acknowledge, 0 = refuse |
| upd_stb | output | 1 | One-cycle strobe for an accepted data byte |
| upd_idx | output | IDX_W | Register index of the accepted byte |
| upd_data | output | 8 | Accepted data byte |
| reg_q | output | NUM_REGS*REG_W | Contents of the stored registers |

## Verification
The address path is swept over all 256 address byte values. The command byte that follows each one shows whether a refused address really drops the rest of the transaction. The write path is swept over both write-protect levels, a band of command codes on both sides of the two valid ones, and several data patterns, including values with bits above REG_W set. This separates the refusals caused by protection from the refusals caused by an unknown command, and it shows truncation to REG_W bits. Directed sequences then toggle protection byte by byte, send several data bytes to one register, and break a transaction with a repeated start. Together these show that the decision is made per byte, that the last accepted byte wins, and that the state is dropped at a start.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_DROP = 2'd3
  } wr_state_e;
endpackage

// File: rtl/i2cw_decode.sv
module i2cw_decode #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int NUM_REGS = 2,
  parameter int CMD_BASE = 16,
  parameter int IDX_W = 1
) (
  input  logic [7:0]       byte_data,
  output logic             addr_hit,
  output logic             cmd_hit,
  output logic [IDX_W-1:0] cmd_idx
);
  logic [NUM_REGS-1:0] sel;

  assign addr_hit = (byte_data[7:1] == DEV_ADDR) && !byte_data[0];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_sel
    assign sel[gi] = (byte_data == 8'(CMD_BASE + gi));
  end

  always_comb begin
    cmd_idx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) cmd_idx = IDX_W'(i);
    end
  end

  assign cmd_hit = |sel;
endmodule

// File: rtl/i2cw_fsm.sv
module i2cw_fsm
  import i2cw_pkg::*;
#(
  parameter int IDX_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wp,
  input  logic             bus_start,
  input  logic             bus_stop,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             addr_hit,
  input  logic             cmd_hit,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic             ack_vld,
  output logic             ack_bit,
  output logic             upd_stb,
  output logic [IDX_W-1:0] upd_idx,
  output logic [7:0]       upd_data
);
  wr_state_e        state, state_nx;
  logic             tgt_ok, tgt_ok_nx;
  logic [IDX_W-1:0] tgt_idx, tgt_idx_nx;
  logic             ack_vld_nx, ack_bit_nx, stb_nx;
  logic [IDX_W-1:0] idx_nx;
  logic [7:0]       data_nx;
  logic             tgt_en, out_en;

  always_comb begin
    state_nx   = state;
    tgt_ok_nx  = tgt_ok;
    tgt_idx_nx = tgt_idx;
    ack_vld_nx = 1'b0;
    ack_bit_nx = 1'b0;
    stb_nx     = 1'b0;
    idx_nx     = upd_idx;
    data_nx    = upd_data;
    if (bus_start || bus_stop) begin
      state_nx = ST_IDLE;
    end else if (byte_valid) begin
      ack_vld_nx = 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (addr_hit) begin
            ack_bit_nx = 1'b1;
            state_nx   = ST_CMD;
          end else begin
            state_nx = ST_DROP;
          end
        end
        ST_CMD: begin
          ack_bit_nx = 1'b1;
          tgt_ok_nx  = cmd_hit;
          tgt_idx_nx = cmd_idx;
          state_nx   = ST_DATA;
        end
        ST_DATA: begin
          if (tgt_ok && !wp) begin
            ack_bit_nx = 1'b1;
            stb_nx     = 1'b1;
            idx_nx     = tgt_idx;
            data_nx    = byte_data;
          end
        end
        default: ;
      endcase
    end
  end

  assign tgt_en = byte_valid && !bus_start && !bus_stop && (state == ST_CMD);
  assign out_en = stb_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ack_vld <= 1'b0;
      ack_bit <= 1'b0;
      upd_stb <= 1'b0;
    end else begin
      state   <= state_nx;
      ack_vld <= ack_vld_nx;
      ack_bit <= ack_bit_nx;
      upd_stb <= stb_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_ok  <= 1'b0;
      tgt_idx <= '0;
    end else if (tgt_en) begin
      tgt_ok  <= tgt_ok_nx;
      tgt_idx <= tgt_idx_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_idx  <= '0;
      upd_data <= '0;
    end else if (out_en) begin
      upd_idx  <= idx_nx;
      upd_data <= data_nx;
    end
  end

  assert_stb_needs_wp_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> !$past(wp));
  assert_stb_with_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |-> (ack_vld && ack_bit));
  assert_drop_refuses_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DROP && byte_valid && !bus_start && !bus_stop) |=> (ack_vld && !ack_bit));
  assert_ack_follows_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !bus_start && !bus_stop) |=> ack_vld);
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs #(
  parameter int NUM_REGS = 2,
  parameter int REG_W = 6,
  parameter int IDX_W = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [7:0]                wr_data,
  output logic [NUM_REGS*REG_W-1:0] q_flat
);
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic             en;
    logic [REG_W-1:0] q;
    assign en = wr_en && (wr_idx == IDX_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (en) q <= wr_data[REG_W-1:0];
    end
    assign q_flat[gi*REG_W +: REG_W] = q;
  end

  assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q_flat));
endmodule

// File: rtl/i2cw_top.sv
module i2cw_top #(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int NUM_REGS = 2,
  parameter int REG_W = 6,
  parameter int CMD_BASE = 16,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wp,
  input  logic                      bus_start,
  input  logic                      bus_stop,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  output logic                      ack_valid,
  output logic                      ack,
  output logic                      upd_stb,
  output logic [IDX_W-1:0]          upd_idx,
  output logic [7:0]                upd_data,
  output logic [NUM_REGS*REG_W-1:0] reg_q
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             addr_hit, cmd_hit;
  logic [IDX_W-1:0] cmd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  i2cw_decode #(
    .DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .CMD_BASE(CMD_BASE), .IDX_W(IDX_W)
  ) u_decode (
    .byte_data(byte_data), .addr_hit(addr_hit), .cmd_hit(cmd_hit), .cmd_idx(cmd_idx)
  );

  i2cw_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .wp(wp), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .addr_hit(addr_hit),
    .cmd_hit(cmd_hit), .cmd_idx(cmd_idx), .ack_vld(ack_valid), .ack_bit(ack),
    .upd_stb(upd_stb), .upd_idx(upd_idx), .upd_data(upd_data)
  );

  i2cw_regs #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(upd_stb), .wr_idx(upd_idx),
    .wr_data(upd_data), .q_flat(reg_q)
  );
endmodule

// File: tb/tb_i2cw_top.sv
module tb_i2cw_top;
  localparam int NREG = 2;
  localparam int RW = 6;
  localparam logic [7:0] ADDR_W = 8'hA0;

  logic clk = 1'b0;
  logic rst_n, wp, bus_start, bus_stop, byte_valid;
  logic [7:0] byte_data;
  logic ack_valid, ack, upd_stb;
  logic [0:0] upd_idx;
  logic [7:0] upd_data;
  logic [NREG*RW-1:0] reg_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [RW-1:0] model [NREG];

  always #4 clk = ~clk;

  i2cw_top dut (
    .clk(clk), .rst_n(rst_n), .wp(wp), .bus_start(bus_start), .bus_stop(bus_stop),
    .byte_valid(byte_valid), .byte_data(byte_data), .ack_valid(ack_valid), .ack(ack),
    .upd_stb(upd_stb), .upd_idx(upd_idx), .upd_data(upd_data), .reg_q(reg_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, 32'(reg_q[i*RW +: RW]), 32'(model[i]));
  endtask

  task automatic pulse_start();
    @(negedge clk); bus_start = 1'b1;
    @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); bus_stop = 1'b1;
    @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, output logic a, output logic s,
                      output logic [0:0] ix, output logic [7:0] d);
    @(negedge clk); byte_valid = 1'b1; byte_data = b;
    @(negedge clk); byte_valid = 1'b0;
    a = ack; s = upd_stb; ix = upd_idx; d = upd_data;
    check("R11 ack_valid after byte", 32'(ack_valid), 32'd1);
    @(negedge clk);
    check("R11 ack_valid idle", 32'(ack_valid), 32'd0);
    check("R4 strobe one cycle", 32'(upd_stb), 32'd0);
  endtask

  initial begin
    logic a, s;
    logic [0:0] ix;
    logic [7:0] d;
    rst_n = 1'b0; wp = 1'b0; bus_start = 1'b0; bus_stop = 1'b0;
    byte_valid = 1'b0; byte_data = '0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ack_valid", 32'(ack_valid), 32'd0);
    check("R1 upd_stb", 32'(upd_stb), 32'd0);
    check_regs("R1 regs zero");
    send(ADDR_W, a, s, ix, d);
    check("R1 first byte is address", 32'(a), 32'd1);
    pulse_stop();

    // R2 address sweep, with the command byte that follows
    for (int b = 0; b < 256; b++) begin
      pulse_start();
      send(8'(b), a, s, ix, d);
      check("R2 address ack", 32'(a), 32'(b == 32'hA0));
      send(8'h10, a, s, ix, d);
      check("R2 follow byte ack", 32'(a), 32'(b == 32'hA0));
      check("R2 no strobe", 32'(s), 32'd0);
      pulse_stop();
    end

    // R3 R4 R5 R6 R8 sweep over wp, command and data
    for (int w = 0; w < 2; w++) begin
      for (int c = 14; c < 20; c++) begin
        for (int k = 0; k < 5; k++) begin
          logic [7:0] dv;
          bit valid, ok;
          dv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h2A :
               (k == 3) ? 8'hD5 : 8'(c * 37 + w * 11 + 3);
          valid = (c == 16) || (c == 17);
          ok = valid && (w == 0);
          wp = 1'(w);
          pulse_start();
          send(ADDR_W, a, s, ix, d);
          check("R3 address ack", 32'(a), 32'd1);
          send(8'(c), a, s, ix, d);
          check("R3 R8 command ack", 32'(a), 32'd1);
          send(dv, a, s, ix, d);
          check("R4 R6 R8 data ack", 32'(a), 32'(ok));
          check("R4 R6 R8 strobe", 32'(s), 32'(ok));
          if (ok) begin
            check("R4 index", 32'(ix), 32'(c - 16));
            check("R4 data", 32'(d), 32'(dv));
            model[c - 16] = dv[RW-1:0];
          end
          check_regs("R5 R6 R8 regs");
          pulse_stop();
        end
      end
    end
    wp = 1'b0;

    // R9 several data bytes to one register
    pulse_start();
    send(ADDR_W, a, s, ix, d);
    send(8'h11, a, s, ix, d);
    send(8'h01, a, s, ix, d); check("R9 byte1 ack", 32'(a), 32'd1);
    send(8'h22, a, s, ix, d); check("R9 byte2 ack", 32'(a), 32'd1);
    send(8'h3C, a, s, ix, d); check("R9 byte3 ack", 32'(a), 32'd1);
    model[1] = 6'h3C;
    check_regs("R9 last byte wins");
    pulse_stop();

    // R7 per-byte write protect
    pulse_start();
    send(ADDR_W, a, s, ix, d);
    send(8'h10, a, s, ix, d);
    wp = 1'b0; send(8'h05, a, s, ix, d); check("R7 unprotected ack", 32'(a), 32'd1);
    model[0] = 6'h05;
    wp = 1'b1; send(8'h0A, a, s, ix, d); check("R7 protected nack", 32'(a), 32'd0);
    check_regs("R7 protected byte kept out");
    wp = 1'b0; send(8'h07, a, s, ix, d); check("R7 unprotected again", 32'(a), 32'd1);
    model[0] = 6'h07;
    check_regs("R7 regs");
    pulse_stop();

    // R10 repeated start drops the transaction
    pulse_start();
    send(ADDR_W, a, s, ix, d);
    send(8'h10, a, s, ix, d);
    pulse_start();
    send(8'h10, a, s, ix, d); check("R10 byte after start is address", 32'(a), 32'd0);
    send(8'h2A, a, s, ix, d); check("R10 dropped data", 32'(a), 32'd0);
    check_regs("R10 regs unchanged");
    pulse_stop();
    // R10 byte beside a stop is ignored
    @(negedge clk); bus_stop = 1'b1; byte_valid = 1'b1; byte_data = ADDR_W;
    @(negedge clk); bus_stop = 1'b0; byte_valid = 1'b0;
    check("R10 byte with stop ignored", 32'(ack_valid), 32'd0);
    send(ADDR_W, a, s, ix, d); check("R10 idle after stop", 32'(a), 32'd1);
    pulse_stop();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule